// File: doc/BRIEF.md
# SONET line overhead inserter

This block sits in the transmit path of a SONET framer, ahead of the scrambler. It receives one byte per clock, and a strobe marks the first byte of each frame. It returns the same stream one clock later with the line overhead filled in. It computes the B2 bit-interleaved parity and writes it into the next frame, places the remote defect code in K2 and the remote error count in Z2, and clears the data-communication and spare line bytes. It can also turn the whole output into line AIS, where every byte is all ones. Section overhead, scrambling and serialization are handled elsewhere.

A rate select picks one of two frame formats. In single STS-1 mode the frame is 9 rows of 90 bytes. In STS-3c mode it is 9 rows of 270 bytes, with three byte-interleaved STS-1s, each of which gets its own B2.

Positions below use the following numbering. Rows run from 0 to 8. Columns run from 0 to 90·N−1, where N is 1 or 3. The STS index of a column is column mod N. Its sub-column is column div N, from 0 to 89.

Top module: `sonet_loh_insert`

## Requirements
- R1: Payload bytes (sub-column 3 or more) appear on `data_o` exactly one clock after they enter on `data_i`, unchanged. The same holds for rows 0 to 3 of sub-columns 0 to 2, and for the K1, S1 (row 8, sub-column 0) and E2 (row 8, sub-column 2) bytes of STS index 0.
- R2: `sof_o` repeats `sof_i` one clock later. Each `sof_i` restarts the grid at row 0, column 0 and latches the rate (`sts3_i` high gives N=3). Without a new `sof_i`, the grid wraps by itself after the last byte.
- R3: In STS-1 mode, B2 (row 4, sub-column 0) carries the even BIP-8. This is the XOR of all output bytes in rows 3 to 8 of the previous frame, across all 90 columns.
- R4: In STS-3c mode, the B2 byte of STS index k carries the XOR of the previous frame's output bytes in rows 3 to 8 whose STS index is k.
- R5: In the first frame after the grid locks (the first `sof_i` after reset), every B2 byte is 00h.
- R6: Every byte clocked in with `ais_i` high leaves as FFh, locked or not. The B2 sums of the next frame include these FFh bytes.
- R7: In the K2 byte of STS index 0 (row 4, sub-column 2), bits [2:0] become 110b while `rdi_i` is high and pass unchanged while it is low. Bits [7:3] always pass.
- R8: The Z2 byte of the last STS index (row 8, sub-column 1, STS index N−1) carries `err_cnt_i`, clamped to a maximum of 24.
- R9: The following bytes leave as 00h: all bytes in rows 5 to 7 with sub-column 0 to 2; K1 and K2 of STS index 1 and 2; and the row 8 bytes of sub-columns 0 to 2 that R1 and R8 do not cover.
- R10: Before the first `sof_i` after reset, the block applies no overhead changes and adds nothing to the B2 sums. Bytes pass unchanged with one clock of latency.
- R11: While reset is held, `data_o` is 00h and `sof_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | High on the first byte of a frame |
| data_i | input | 8 | Incoming byte |
| sts3_i | input | 1 | Rate select, latched at `sof_i`: 1 = STS-3c, 0 = STS-1 |
| ais_i | input | 1 | Force the current byte to FFh |
| rdi_i | input | 1 | Insert the remote defect code into K2 |
| err_cnt_i | input | ERR_W | Remote error count for Z2 |
| data_o | output | 8 | Outgoing byte, one clock after input |
| sof_o | output | 1 | Frame start, aligned with `data_o` |

## Verification
Random payload bytes run through frames at both rates. This separates the B2 sums per STS index from a single sum over the whole frame, and it shows any byte that is misplaced or overwritten. One frame under full AIS checks that B2 returns to zero afterwards, and a later STS-3c frame with AIS applied to only part of it gives nonzero parity that proves the FFh bytes are counted. Error counts of 5, 24, 30 and 255 test the clamp at and above the limit, and toggling `rdi_i` separates the K2 code from a pass-through. A frame that wraps with no strobe, followed by a restart in the middle of a frame, tests the grid counter and a B2 computed over a partial frame.

// File: rtl/sonet_loh_pkg.sv
package sonet_loh_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ROWS     = 9;
  localparam int unsigned SUB_COLS = 90;
  localparam int unsigned OH_COLS  = 3;
  localparam int unsigned MAX_STS  = 3;
  localparam int unsigned PTR_ROW  = 3;  // first row covered by B2
  localparam int unsigned B2_ROW   = 4;
  localparam int unsigned SYNC_ROW = 8;
  localparam int unsigned RDI_W    = 3;
  localparam logic [RDI_W-1:0] RDI_CODE = 3'b110;
  localparam int unsigned ROW_W = $clog2(ROWS);
  localparam int unsigned SUB_W = $clog2(SUB_COLS);
  localparam int unsigned STS_W = $clog2(MAX_STS);

  typedef struct packed {
    logic [ROW_W-1:0] row;
    logic [SUB_W-1:0] sub;
    logic [STS_W-1:0] sts;
  } pos_t;

  typedef enum logic [2:0] {K_PASS, K_B2, K_K2, K_Z2, K_ZERO} kind_t;
endpackage

// File: rtl/loh_frame_pos.sv
module loh_frame_pos
  import sonet_loh_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             sts3_i,
  output pos_t             pos_o,
  output logic             locked_o,
  output logic             frame_start_o,
  output logic [STS_W-1:0] last_sts_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_COLS - 1);
  localparam logic [STS_W-1:0] STS_MAXI = STS_W'(MAX_STS - 1);

  pos_t             nxt_q, pos_cur, pos_inc;
  logic             locked_q;
  logic [STS_W-1:0] last_q, last_cur;

  always_comb begin
    last_cur = sof_i ? (sts3_i ? STS_MAXI : '0) : last_q;
    pos_cur  = sof_i ? '0 : nxt_q;
    pos_inc  = pos_cur;
    if (pos_cur.sts != last_cur) begin
      pos_inc.sts = pos_cur.sts + STS_W'(1);
    end else begin
      pos_inc.sts = '0;
      if (pos_cur.sub != SUB_LAST) begin
        pos_inc.sub = pos_cur.sub + SUB_W'(1);
      end else begin
        pos_inc.sub = '0;
        pos_inc.row = (pos_cur.row == ROW_LAST) ? '0 : pos_cur.row + ROW_W'(1);
      end
    end
  end

  assign locked_o      = sof_i | locked_q;
  assign frame_start_o = locked_o && (pos_cur == '0);
  assign pos_o         = pos_cur;
  assign last_sts_o    = last_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q    <= '0;
      locked_q <= 1'b0;
      last_q   <= '0;
    end else begin
      if (sof_i) begin
        locked_q <= 1'b1;
        last_q   <= last_cur;
      end
      if (locked_o) nxt_q <= pos_inc;
    end
  end
endmodule

// File: rtl/loh_bip_bank.sv
module loh_bip_bank
  import sonet_loh_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             commit_i,
  input  logic                             acc_en_i,
  input  logic [STS_W-1:0]                 sts_i,
  input  logic [BYTE_W-1:0]                byte_i,
  output logic [MAX_STS-1:0][BYTE_W-1:0]   held_o
);
  logic [MAX_STS-1:0][BYTE_W-1:0] acc_q, held_q;

  for (genvar k = 0; k < MAX_STS; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[k]  <= '0;
        held_q[k] <= '0;
      end else if (commit_i) begin
        held_q[k] <= acc_q[k];
        acc_q[k]  <= '0;
      end else if (acc_en_i && sts_i == STS_W'(k)) begin
        acc_q[k]  <= acc_q[k] ^ byte_i;
      end
    end
  end

  assign held_o = held_q;
endmodule

// File: rtl/loh_byte_mux.sv
module loh_byte_mux
  import sonet_loh_pkg::*;
#(
  parameter int unsigned ERR_W  = 8,
  parameter int unsigned Z2_MAX = 24
) (
  input  pos_t                           pos_i,
  input  logic                           locked_i,
  input  logic [STS_W-1:0]               last_sts_i,
  input  logic [BYTE_W-1:0]              data_i,
  input  logic                           ais_i,
  input  logic                           rdi_i,
  input  logic [ERR_W-1:0]               err_i,
  input  logic [MAX_STS-1:0][BYTE_W-1:0] held_i,
  output logic [BYTE_W-1:0]              byte_o,
  output logic                           cover_o
);
  kind_t             kind;
  logic [BYTE_W-1:0] z2_val;
  logic              first_sts, in_loh;

  assign first_sts = (pos_i.sts == '0);
  assign in_loh    = locked_i && (pos_i.sub < SUB_W'(OH_COLS)) && (pos_i.row > ROW_W'(PTR_ROW));
  assign cover_o   = locked_i && (pos_i.row >= ROW_W'(PTR_ROW));
  assign z2_val    = (err_i > ERR_W'(Z2_MAX)) ? BYTE_W'(Z2_MAX) : BYTE_W'(err_i);

  always_comb begin
    kind = K_PASS;
    if (in_loh) begin
      if (pos_i.row == ROW_W'(B2_ROW)) begin
        if (pos_i.sub == SUB_W'(0))      kind = K_B2;
        else if (pos_i.sub == SUB_W'(1)) kind = first_sts ? K_PASS : K_ZERO;
        else                             kind = first_sts ? K_K2 : K_ZERO;
      end else if (pos_i.row == ROW_W'(SYNC_ROW)) begin
        if (pos_i.sub == SUB_W'(1))      kind = (pos_i.sts == last_sts_i) ? K_Z2 : K_ZERO;
        else                             kind = first_sts ? K_PASS : K_ZERO;
      end else begin
        kind = K_ZERO;  // line DCC rows
      end
    end
  end

  always_comb begin
    unique case (kind)
      K_B2:    byte_o = held_i[pos_i.sts];
      K_K2:    byte_o = {data_i[BYTE_W-1:RDI_W], rdi_i ? RDI_CODE : data_i[RDI_W-1:0]};
      K_Z2:    byte_o = z2_val;
      K_ZERO:  byte_o = '0;
      default: byte_o = data_i;
    endcase
    if (ais_i) byte_o = '1;
  end
endmodule

// File: rtl/sonet_loh_insert.sv
module sonet_loh_insert
  import sonet_loh_pkg::*;
#(
  parameter int unsigned ERR_W  = 8,
  parameter int unsigned Z2_MAX = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              sts3_i,
  input  logic              ais_i,
  input  logic              rdi_i,
  input  logic [ERR_W-1:0]  err_cnt_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              sof_o
);
  pos_t                           pos_w;
  logic                           locked_w, frame_start_w, cover_w;
  logic [STS_W-1:0]               last_sts_w;
  logic [MAX_STS-1:0][BYTE_W-1:0] held_w;
  logic [BYTE_W-1:0]              out_d;

  loh_frame_pos u_pos (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sof_i         (sof_i),
    .sts3_i        (sts3_i),
    .pos_o         (pos_w),
    .locked_o      (locked_w),
    .frame_start_o (frame_start_w),
    .last_sts_o    (last_sts_w)
  );

  loh_byte_mux #(.ERR_W(ERR_W), .Z2_MAX(Z2_MAX)) u_mux (
    .pos_i      (pos_w),
    .locked_i   (locked_w),
    .last_sts_i (last_sts_w),
    .data_i     (data_i),
    .ais_i      (ais_i),
    .rdi_i      (rdi_i),
    .err_i      (err_cnt_i),
    .held_i     (held_w),
    .byte_o     (out_d),
    .cover_o    (cover_w)
  );

  // parity taken on the outgoing byte, before the scrambler
  loh_bip_bank u_bip (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (frame_start_w),
    .acc_en_i (cover_w),
    .sts_i    (pos_w.sts),
    .byte_i   (out_d),
    .held_o   (held_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      sof_o  <= 1'b0;
    end else begin
      data_o <= out_d;
      sof_o  <= sof_i;
    end
  end
endmodule

// File: rtl/sonet_loh_insert_chk.sv
module sonet_loh_insert_chk
  import sonet_loh_pkg::*;
#(
  parameter int unsigned Z2_MAX = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sof_i,
  input logic              ais_i,
  input logic [BYTE_W-1:0] data_i,
  input logic [BYTE_W-1:0] data_o,
  input logic              sof_o,
  input pos_t              pos,
  input logic              locked,
  input logic [STS_W-1:0]  last_sts
);
  logic oh_col, dcc_row, z2_spot;
  assign oh_col  = pos.sub < SUB_W'(OH_COLS);
  assign dcc_row = pos.row > ROW_W'(B2_ROW) && pos.row < ROW_W'(SYNC_ROW);
  assign z2_spot = pos.row == ROW_W'(SYNC_ROW) && pos.sub == SUB_W'(1) && pos.sts == last_sts;

  a_r1_payload_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && !oh_col && !ais_i) |=> data_o == $past(data_i));

  a_r2_sof_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> sof_o);

  a_r6_ais_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ais_i |=> data_o == '1);

  a_r8_z2_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && !ais_i && z2_spot) |=> data_o <= BYTE_W'(Z2_MAX));

  a_r9_dcc_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && !ais_i && oh_col && dcc_row) |=> data_o == '0);

  a_r10_unlocked_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked && !ais_i) |=> data_o == $past(data_i));
endmodule

bind sonet_loh_insert sonet_loh_insert_chk #(.Z2_MAX(Z2_MAX)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sof_i    (sof_i),
  .ais_i    (ais_i),
  .data_i   (data_i),
  .data_o   (data_o),
  .sof_o    (sof_o),
  .pos      (pos_w),
  .locked   (locked_w),
  .last_sts (last_sts_w)
);

// File: tb/sonet_loh_insert_tb.sv
`timescale 1ns/1ps
module sonet_loh_insert_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0, sts3 = 1'b0, ais = 1'b0, rdi = 1'b0;
  logic [7:0] din = '0, err = '0;
  logic [7:0] dout;
  logic       sof_out;

  always #2 clk = ~clk;

  sonet_loh_insert u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .data_i(din), .sts3_i(sts3),
    .ais_i(ais), .rdi_i(rdi), .err_cnt_i(err), .data_o(dout), .sof_o(sof_out)
  );

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  // reference model state
  bit    m_locked = 0, m_first = 0;
  int    m_row = 0, m_sub = 0, m_sts = 0, m_n = 1;
  int    m_acc[3], m_held[3];
  logic [7:0] exp_d = '0;
  logic       exp_sof = 1'b0;
  string      exp_tag = "R11";

  task automatic commit();
    for (int k = 0; k < 3; k++) begin
      m_held[k] = m_acc[k];
      m_acc[k]  = 0;
    end
  endtask

  task automatic model(input bit s, input logic [7:0] d, input bit a, input bit r,
                       input logic [7:0] e, input bit st3);
    logic [7:0] x;
    string t;
    if (s) begin
      m_first  = !m_locked;
      m_locked = 1;
      m_n = st3 ? 3 : 1;
      m_row = 0; m_sub = 0; m_sts = 0;
      commit();
    end else if (m_locked) begin
      m_sts++;
      if (m_sts == m_n) begin
        m_sts = 0; m_sub++;
        if (m_sub == 90) begin
          m_sub = 0; m_row++;
          if (m_row == 9) m_row = 0;
        end
      end
      if (m_row == 0 && m_sub == 0 && m_sts == 0) begin
        m_first = 0;
        commit();
      end
    end
    x = d; t = "R1";
    if (a) begin x = 8'hFF; t = "R6"; end
    else if (!m_locked) begin x = d; t = "R10"; end
    else if (m_sub >= 3 || m_row <= 3) begin x = d; t = "R1"; end
    else if (m_row == 4) begin
      if (m_sub == 0) begin
        x = 8'(m_held[m_sts]);
        t = m_first ? "R5" : (m_n == 1 ? "R3" : "R4");
      end else if (m_sts != 0) begin x = 8'h00; t = "R9"; end
      else if (m_sub == 1) begin x = d; t = "R1"; end
      else begin x = {d[7:3], r ? 3'b110 : d[2:0]}; t = "R7"; end
    end else if (m_row < 8) begin x = 8'h00; t = "R9"; end
    else begin
      if (m_sub == 1) begin
        if (m_sts == m_n - 1) begin x = (e > 8'd24) ? 8'd24 : e; t = "R8"; end
        else begin x = 8'h00; t = "R9"; end
      end else if (m_sts == 0) begin x = d; t = "R1"; end
      else begin x = 8'h00; t = "R9"; end
    end
    if (m_locked && m_row >= 3) m_acc[m_sts] = m_acc[m_sts] ^ int'(x);
    exp_d = x; exp_sof = s; exp_tag = t;
  endtask

  task automatic compare();
    checks++;
    if (dout !== exp_d) begin
      errors++;
      $display("FAIL %s: data_o=%02h expected %02h", exp_tag, dout, exp_d);
    end
    checks++;
    if (sof_out !== exp_sof) begin
      errors++;
      $display("FAIL R2: sof_o=%0b expected %0b", sof_out, exp_sof);
    end
  endtask

  task automatic step(input bit s, input bit a, input bit r, input logic [7:0] e, input bit st3);
    logic [7:0] d;
    compare();
    d = 8'($urandom);
    sof = s; din = d; ais = a; rdi = r; err = e; sts3 = st3;
    model(s, d, a, r, e, st3);
    @(negedge clk);
  endtask

  task automatic frame(input bit st3, input bit with_sof, input int nbytes,
                       input bit a, input bit r, input logic [7:0] e, input int ais_until);
    for (int i = 0; i < nbytes; i++)
      step(with_sof && i == 0, a || i < ais_until, r, e, st3);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin m_acc[k] = 0; m_held[k] = 0; end
    repeat (5) @(negedge clk);
    compare();  // R11 reset state
    rst_n = 1'b1;
    // R10: before lock, then R6 before lock
    for (int i = 0; i < 40; i++) step(0, 0, 1, 8'd9, 0);
    for (int i = 0; i < 5; i++)  step(0, 1, 0, 8'd9, 0);
    // STS-1 frames: R5 first, R3 after, R7 toggled, R8 clamp
    frame(0, 1, 810, 0, 1, 8'd5,   0);
    frame(0, 1, 810, 0, 0, 8'd30,  0);
    frame(0, 1, 810, 1, 1, 8'd3,   0);  // full AIS frame
    frame(0, 1, 810, 0, 1, 8'd24,  0);  // B2 after AIS
    frame(0, 0, 810, 0, 0, 8'd0,   0);  // R2 wrap without strobe
    frame(0, 1, 400, 0, 1, 8'd1,   0);  // cut short
    // STS-3c: R4 per-lane parity, restart mid-frame
    frame(1, 1, 2430, 0, 1, 8'h18, 0);
    frame(1, 1, 2430, 0, 0, 8'hFF, 0);
    frame(1, 1, 2430, 0, 1, 8'd7,  1000);  // partial AIS
    frame(1, 1, 2430, 0, 0, 8'd25, 0);
    step(0, 0, 0, 8'd0, 1);
    compare();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end
endmodule